// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block brings one switchable logic domain up and down in a fixed, safe order. On a power-on command it closes the domain's power switches at the gentlest inrush-current setting. If the supply does not report good within a bounded wait, it raises the current allowance one step and waits again. Once power is good, it lifts electrical isolation, runs a memory-repair handshake and then lifts functional isolation. On a power-off command it restores both isolations and opens the switches.

Commands are single-cycle pulses that are taken only while the sequencer is idle. Each accepted command ends with a one-cycle `done` pulse, or with an `err` pulse when a wait times out. The two wait bounds are cycle-count parameters. At the default 250 MHz clock they are 750 cycles for power-good, about 3 µs, and 250 cycles for repair, about 1 µs. The switch fabric and the repair engine are outside the block. Reset is asserted asynchronously and released through a two-stage synchronizer, so the sequencer leaves reset two clock edges after `rst_n` rises.

Top module: `pdsw_seq`

## Requirements
- R1: During and after reset, every output is 0: switch enable, inrush code, both isolation releases, repair request, busy, done and err.
- R2: A power-on command taken while idle with the switch open sets the switch enable with inrush code 0. The 2-bit code means 0 = 3.5 mA, 1 = 5 mA, 2 = 10 mA, 3 = 20 mA.
- R3: At each inrush level the sequencer waits PGOOD_WAIT_CYC cycles for power-good and then raises the code by exactly one. The code in force when power-good arrives is kept after the power-on completes.
- R4: If power-good is still low at the end of the wait at code 3, the sequencer clears the switch enable and the code to 0 and pulses err. Busy is high for exactly 4 × PGOOD_WAIT_CYC cycles.
- R5: After power-good, electrical isolation is released first, and the repair request rises only on a later cycle while electrical isolation stays released.
- R6: If repair-done does not arrive within REPAIR_WAIT_CYC cycles, the sequencer re-applies electrical isolation, drops the repair request, clears the switch enable and the code, and pulses err.
- R7: Functional isolation is released only on repair-done. In the same step the repair request drops and done pulses.
- R8: A power-on command that finds the switch enable already set gives a done pulse on the next cycle. No other output changes and busy stays low.
- R9: A power-off command applies functional isolation first. One cycle later it applies electrical isolation, and one cycle after that it clears the switch enable and the code and pulses done.
- R10: Commands that arrive while busy have no effect. If both commands arrive together while idle, power-on is taken.
- R11: Done and err last one cycle each, never occur together, and busy is low whenever either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | 1 | Power-on command pulse |
| cmd_off | input | 1 | Power-off command pulse |
| pwr_good | input | 1 | Power-good status from the switch fabric |
| rep_done | input | 1 | Memory repair finished |
| sw_en | output | 1 | Power-switch enable |
| inrush_code | output | 2 | Inrush-current limit code |
| iso_elec_rel | output | 1 | 1 = electrical isolation released |
| mem_rep_req | output | 1 | Memory repair request |
| iso_func_rel | output | 1 | 1 = functional isolation released |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout pulse |

## Verification
The properties assume that `pwr_good` and `rep_done` are level responses from models that react to the block's own `sw_en` and `mem_rep_req`. They also assume that repair-done never arrives without a request outstanding. The bench meets this with a switch model that raises power-good a few cycles after the enable is set and the code reaches a chosen threshold. Its repair model answers a request after a short fixed delay, and can be told to stay silent. Both model delays are kept well under the timeout parameters, so each retry level and each repair wait resolves the way the test intends. Commands are driven as one-cycle pulses on the falling edge.

// File: rtl/pdsw_pkg.sv
package pdsw_pkg;
  localparam int INRUSH_W = 2;
  typedef logic [INRUSH_W-1:0] inrush_t;
  localparam inrush_t INRUSH_LOW = '0;
  localparam inrush_t INRUSH_TOP = '1;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PWAIT = 3'd1,
    ST_REQ   = 3'd2,
    ST_RWAIT = 3'd3,
    ST_OFF_E = 3'd4,
    ST_OFF_S = 3'd5
  } pdsw_state_e;
endpackage

// File: rtl/pdsw_rst_sync.sv
module pdsw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pdsw_timer.sv
module pdsw_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pdsw_fsm.sv
module pdsw_fsm
  import pdsw_pkg::*;
#(
  parameter int CW      = 10,
  parameter int PG_LOAD = 11,
  parameter int RP_LOAD = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_on,
  input  logic          cmd_off,
  input  logic          pwr_good,
  input  logic          rep_done,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          sw_en,
  output inrush_t       inrush_code,
  output logic          iso_elec_rel,
  output logic          mem_rep_req,
  output logic          iso_func_rel,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam logic [CW-1:0] PG_VAL = CW'(PG_LOAD);
  localparam logic [CW-1:0] RP_VAL = CW'(RP_LOAD);

  pdsw_state_e st_q, st_d;
  logic    sw_q, sw_d;
  inrush_t code_q, code_d;
  logic    elec_q, elec_d;
  logic    req_q, req_d;
  logic    func_q, func_d;
  logic    done_q, done_d;
  logic    err_q, err_d;

  always_comb begin
    st_d     = st_q;
    sw_d     = sw_q;
    code_d   = code_q;
    elec_d   = elec_q;
    req_d    = req_q;
    func_d   = func_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_on) begin
          if (sw_q) begin
            done_d = 1'b1;
          end else begin
            sw_d     = 1'b1;
            code_d   = INRUSH_LOW;
            tmr_load = 1'b1;
            tmr_val  = PG_VAL;
            st_d     = ST_PWAIT;
          end
        end else if (cmd_off) begin
          func_d = 1'b0;
          st_d   = ST_OFF_E;
        end
      end
      ST_PWAIT: begin
        if (pwr_good) begin
          elec_d = 1'b1;
          st_d   = ST_REQ;
        end else if (tmr_zero) begin
          if (code_q == INRUSH_TOP) begin
            sw_d   = 1'b0;
            code_d = INRUSH_LOW;
            err_d  = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            code_d   = code_q + 1'b1;
            tmr_load = 1'b1;
            tmr_val  = PG_VAL;
          end
        end
      end
      ST_REQ: begin
        req_d    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = RP_VAL;
        st_d     = ST_RWAIT;
      end
      ST_RWAIT: begin
        if (rep_done) begin
          req_d  = 1'b0;
          func_d = 1'b1;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (tmr_zero) begin
          req_d  = 1'b0;
          elec_d = 1'b0;
          sw_d   = 1'b0;
          code_d = INRUSH_LOW;
          err_d  = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_OFF_E: begin
        elec_d = 1'b0;
        st_d   = ST_OFF_S;
      end
      ST_OFF_S: begin
        sw_d   = 1'b0;
        code_d = INRUSH_LOW;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sw_q   <= 1'b0;
      code_q <= INRUSH_LOW;
      elec_q <= 1'b0;
      req_q  <= 1'b0;
      func_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sw_q   <= sw_d;
      code_q <= code_d;
      elec_q <= elec_d;
      req_q  <= req_d;
      func_q <= func_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign sw_en        = sw_q;
  assign inrush_code  = code_q;
  assign iso_elec_rel = elec_q;
  assign mem_rep_req  = req_q;
  assign iso_func_rel = func_q;
  assign busy         = (st_q != ST_IDLE);
  assign done         = done_q;
  assign err          = err_q;
endmodule

// File: rtl/pdsw_seq.sv
module pdsw_seq #(
  parameter int PGOOD_WAIT_CYC  = 750,
  parameter int REPAIR_WAIT_CYC = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_on,
  input  logic       cmd_off,
  input  logic       pwr_good,
  input  logic       rep_done,
  output logic       sw_en,
  output logic [1:0] inrush_code,
  output logic       iso_elec_rel,
  output logic       mem_rep_req,
  output logic       iso_func_rel,
  output logic       busy,
  output logic       done,
  output logic       err
);
  localparam int WAIT_MAX = (PGOOD_WAIT_CYC > REPAIR_WAIT_CYC) ? PGOOD_WAIT_CYC : REPAIR_WAIT_CYC;
  localparam int CW       = $clog2(WAIT_MAX + 1);

  logic          rst_int_n;
  logic          tmr_load;
  logic          tmr_zero;
  logic [CW-1:0] tmr_val;

  pdsw_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  pdsw_timer #(.CW(CW)) timer_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  pdsw_fsm #(
    .CW     (CW),
    .PG_LOAD(PGOOD_WAIT_CYC - 1),
    .RP_LOAD(REPAIR_WAIT_CYC - 1)
  ) fsm_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cmd_on      (cmd_on),
    .cmd_off     (cmd_off),
    .pwr_good    (pwr_good),
    .rep_done    (rep_done),
    .tmr_zero    (tmr_zero),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .sw_en       (sw_en),
    .inrush_code (inrush_code),
    .iso_elec_rel(iso_elec_rel),
    .mem_rep_req (mem_rep_req),
    .iso_func_rel(iso_func_rel),
    .busy        (busy),
    .done        (done),
    .err         (err)
  );
endmodule

// File: rtl/pdsw_seq_chk.sv
module pdsw_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_en,
  input logic [1:0] inrush_code,
  input logic       iso_elec_rel,
  input logic       mem_rep_req,
  input logic       iso_func_rel,
  input logic       busy,
  input logic       done,
  input logic       err
);
  // R5: repair is requested only with electrical isolation released
  p_req_needs_elec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rep_req |-> iso_elec_rel);
  // R5: electrical isolation is released only with the switch closed
  p_elec_needs_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iso_elec_rel |-> sw_en);
  // R7: functional release only on a fully powered domain
  p_func_needs_power_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iso_func_rel |-> (sw_en && iso_elec_rel && !mem_rep_req));
  // R3: the inrush code only steps up by one during a sequence
  p_code_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$stable(inrush_code)) |-> (inrush_code == $past(inrush_code) + 2'd1));
  // R9: electrical isolation is re-applied only after functional isolation
  p_off_elec_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_elec_rel) |-> !iso_func_rel);
  // R9: switches open only with electrical isolation applied
  p_off_sw_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en) |-> !iso_elec_rel);
  // R11: single-cycle pulses
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (!busy && !(done && err)));
endmodule

bind pdsw_seq pdsw_seq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_en       (sw_en),
  .inrush_code (inrush_code),
  .iso_elec_rel(iso_elec_rel),
  .mem_rep_req (mem_rep_req),
  .iso_func_rel(iso_func_rel),
  .busy        (busy),
  .done        (done),
  .err         (err)
);

// File: tb/pdsw_seq_tb.sv
module pdsw_seq_tb_top;
  localparam int PG  = 12;
  localparam int RP  = 8;
  localparam int PGD = 3;
  localparam int RD  = 2;

  logic clk;
  logic rst_n;
  logic cmd_on, cmd_off, pwr_good, rep_done;
  logic sw_en, iso_elec_rel, mem_rep_req, iso_func_rel, busy, done, err;
  logic [1:0] inrush_code;

  pdsw_seq #(.PGOOD_WAIT_CYC(PG), .REPAIR_WAIT_CYC(RP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .pwr_good(pwr_good), .rep_done(rep_done), .sw_en(sw_en),
    .inrush_code(inrush_code), .iso_elec_rel(iso_elec_rel),
    .mem_rep_req(mem_rep_req), .iso_func_rel(iso_func_rel),
    .busy(busy), .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // switch model: power good PGD cycles after enable with code at threshold
  int   thr = 0;
  int   pg_cnt = 0;
  always @(posedge clk) begin
    if (!sw_en || int'(inrush_code) < thr) pg_cnt <= 0;
    else if (pg_cnt < PGD)                 pg_cnt <= pg_cnt + 1;
  end
  assign pwr_good = sw_en && (pg_cnt == PGD);

  // repair model
  logic rep_en = 1'b1;
  int   rp_cnt = 0;
  always @(posedge clk) begin
    if (!mem_rep_req)   rp_cnt <= 0;
    else if (rp_cnt < RD) rp_cnt <= rp_cnt + 1;
  end
  assign rep_done = rep_en && mem_rep_req && (rp_cnt == RD);

  // scoreboard
  logic [6:0] exp_q[$];
  string      tag_q[$];
  logic       mon_on = 1'b0;
  logic       prev_done = 1'b0, prev_err = 1'b0, prev_req = 1'b0;
  logic       prev_func = 1'b0, prev_elec = 1'b0, prev_sw = 1'b0;
  int         busy_run = 0, last_busy = 0;
  int         t_func = 0, t_elec = 0, t_sw = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (busy) busy_run = busy_run + 1;
      if (done || err) begin
        last_busy = busy_run;
        busy_run  = 0;
        if (exp_q.size() == 0) begin
          chk("R11 unexpected pulse", 32'(done), 32'(0));
        end else begin
          logic [6:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, {25'd0, err, sw_en, inrush_code, iso_elec_rel, mem_rep_req, iso_func_rel},
              {25'd0, e});
        end
      end
      if ((done && prev_done) || (err && prev_err)) chk("R11 pulse width", 32'(1), 32'(0));
      if (mem_rep_req && !prev_req) chk("R5 elec released before request", 32'(iso_elec_rel), 32'(1));
      if (!iso_func_rel && prev_func) t_func = cyc;
      if (!iso_elec_rel && prev_elec) t_elec = cyc;
      if (!sw_en && prev_sw) t_sw = cyc;
      prev_done = done; prev_err = err; prev_req = mem_rep_req;
      prev_func = iso_func_rel; prev_elec = iso_elec_rel; prev_sw = sw_en;
    end
  end

  task automatic run_cmd(input logic on, input logic off, input logic exp_err,
                         input logic [5:0] exp_vec, input string tag, input bit poke);
    exp_q.push_back({exp_err, exp_vec});
    tag_q.push_back(tag);
    @(negedge clk); cmd_on = on; cmd_off = off;
    @(negedge clk); cmd_on = 1'b0; cmd_off = 1'b0;
    if (poke) begin
      @(negedge clk); cmd_on = 1'b1; cmd_off = 1'b1;
      @(negedge clk); cmd_on = 1'b0; cmd_off = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 100000; wd++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", wd);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cmd_on = 1'b0; cmd_off = 1'b0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state while reset held
    chk("R1 outputs in reset", {24'd0, sw_en, inrush_code, iso_elec_rel, mem_rep_req,
        iso_func_rel, busy, done, err}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 outputs after reset", {24'd0, sw_en, inrush_code, iso_elec_rel, mem_rep_req,
        iso_func_rel, busy, done, err}, 32'd0);
    mon_on = 1'b1;

    // R2 R7: power-on at lowest inrush code
    thr = 0;
    run_cmd(1'b1, 1'b0, 1'b0, 6'b1_00_101, "R2 R7 on at code 0", 1'b0);

    // R9: power-off order
    t_func = 0; t_elec = 0; t_sw = 0;
    run_cmd(1'b0, 1'b1, 1'b0, 6'b0_00_000, "R9 off", 1'b0);
    chk("R9 elec one cycle after func", 32'(t_elec - t_func), 32'd1);
    chk("R9 switch one cycle after elec", 32'(t_sw - t_elec), 32'd1);

    // R3: retries up to code 2
    thr = 2;
    run_cmd(1'b1, 1'b0, 1'b0, 6'b1_10_101, "R3 on at code 2", 1'b0);
    run_cmd(1'b0, 1'b1, 1'b0, 6'b0_00_000, "R9 off after code 2", 1'b0);

    // R3: top code succeeds
    thr = 3;
    run_cmd(1'b1, 1'b0, 1'b0, 6'b1_11_101, "R3 on at code 3", 1'b0);
    run_cmd(1'b0, 1'b1, 1'b0, 6'b0_00_000, "R9 off after code 3", 1'b0);

    // R4: power-good never arrives
    thr = 4;
    run_cmd(1'b1, 1'b0, 1'b1, 6'b0_00_000, "R4 power-good timeout", 1'b0);
    chk("R4 busy cycles", 32'(last_busy), 32'(4 * PG));

    // R6: repair never completes
    thr = 0; rep_en = 1'b0;
    run_cmd(1'b1, 1'b0, 1'b1, 6'b0_00_000, "R6 repair timeout", 1'b0);
    rep_en = 1'b1;

    // R10: commands while busy ignored
    thr = 1;
    run_cmd(1'b1, 1'b0, 1'b0, 6'b1_01_101, "R10 on with busy pokes", 1'b1);

    // R8: already on
    run_cmd(1'b1, 1'b0, 1'b0, 6'b1_01_101, "R8 on when already on", 1'b0);
    chk("R8 busy stays low", 32'(last_busy), 32'd0);

    // R10: both commands while idle and off -> power-on taken
    run_cmd(1'b0, 1'b1, 1'b0, 6'b0_00_000, "R9 off before both", 1'b0);
    thr = 0;
    run_cmd(1'b1, 1'b1, 1'b0, 6'b1_00_101, "R10 both commands take on", 1'b0);
    chk("R11 idle after sequences", {31'd0, busy}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule